// File: doc/BRIEF.md
# Watchdog Timer with Selectable Source and Underflow Action

This block is a software-serviced watchdog. A down counter, by default 15 bits wide, advances once for every sixteen ticks of a chosen time base. The time base is either the processor clock or a slow ring-oscillator clock. Neither oscillator is modelled here. Each one appears as a single-cycle enable strobe that is synchronous to `clk`. Software must write the service strobe often enough that the counter never passes zero. A service write loads the counter with all ones and also clears the prescaler, so every service restarts the full timeout.

When the counter steps past zero it wraps back to all ones and keeps running. What happens at that moment depends on the action select. In interrupt mode the block emits a one-cycle interrupt request. In reset mode it asserts a reset request for a fixed number of clock cycles. A hold input freezes the time base, for example while a debugger has the core halted.

Top module: `wdt_mode_timer`

## Requirements
- R1: After `rst_n` is released, `irq_o` and `rst_req_o` are low, the counter holds all ones and the prescaler holds zero.
- R2: A cycle with `service_wr` high loads the counter with all ones and clears the prescaler. If a tick arrives in that same cycle, it is not counted.
- R3: The counter steps once every `PRE_DIV` counted ticks. The underflow happens on counted tick number (2^`CNT_W`)·`PRE_DIV` after a reload.
- R4: Only ticks from the selected source are counted. `src_sel`=0 selects `cpu_tick` and `src_sel`=1 selects `ring_tick`.
- R5: With `mode_sel`=0 (interrupt action), an underflow drives `irq_o` high for exactly one cycle, in the cycle after the edge that counted the final tick.
- R6: With `mode_sel`=1 (reset action), an underflow leaves `irq_o` low. It drives `rst_req_o` high for exactly `RST_HOLD` cycles, starting in the cycle after that edge.
- R7: After an underflow the counter reloads to all ones by itself. The next underflow comes after another (2^`CNT_W`)·`PRE_DIV` counted ticks.
- R8: Ticks that arrive while `hold` is high are not counted.
- R9: The action is taken from `mode_sel` as sampled on the edge of the underflow, not from its value at the last service write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_tick | input | 1 | One-cycle enable strobe from the processor clock source |
| ring_tick | input | 1 | One-cycle enable strobe from the ring oscillator source |
| src_sel | input | 1 | Time base select: 0 = processor clock, 1 = ring oscillator |
| mode_sel | input | 1 | Underflow action: 0 = interrupt, 1 = reset |
| service_wr | input | 1 | Service register write strobe |
| hold | input | 1 | Freezes the time base while high |
| irq_o | output | 1 | Interrupt request, one-cycle pulse |
| rst_req_o | output | 1 | Reset request, stretched to `RST_HOLD` cycles |

## Verification
The hardest cases to reach from the ports are the ones that turn on a single tick. One is a service write that lands on an edge that also carries a tick. Another is a service write made when the prescaler is partly filled. A third is a change of action made just before the final tick. None of these can be seen directly, because the counter and prescaler are internal. The bench therefore uses a reduced configuration (4-bit counter, divide by 4), where a full timeout is only 64 ticks. It applies ticks one at a time and counts them. For every offset from 1 to 63 it runs a service write after that many ticks, then confirms that the event comes on exactly the 64th tick afterwards.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic {
        SRC_CPU  = 1'b0,
        SRC_RING = 1'b1
    } wdt_src_e;

    typedef enum logic {
        ACT_IRQ   = 1'b0,
        ACT_RESET = 1'b1
    } wdt_act_e;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic step
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_state_t;

    pre_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        step  = 1'b0;
        if (clear) begin
            nxt_d.phase = '0;
        end else if (tick) begin
            if (cur_q.phase == LAST) begin
                nxt_d.phase = '0;
                step        = 1'b1;
            end else begin
                nxt_d.phase = cur_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
    parameter int CNT_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic step,
    output logic underflow
);
    localparam logic [CNT_W-1:0] FULL = '1;

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        underflow = 1'b0;
        if (reload) begin
            nxt_d.count = FULL;
        end else if (step) begin
            if (cur_q.count == '0) begin
                nxt_d.count = FULL;
                underflow   = 1'b1;
            end else begin
                nxt_d.count = cur_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{count: FULL};
        else        cur_q <= nxt_d;
    end

endmodule

// File: rtl/wdt_reset_stretch.sv
module wdt_reset_stretch #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);
    localparam int HW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [HW-1:0] left;
    } str_state_t;

    str_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (fire) begin
            nxt_d.left = HW'(HOLD);
        end else if (cur_q.left != '0) begin
            nxt_d.left = cur_q.left - 1'b1;
        end
    end

    assign active = (cur_q.left != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

endmodule

// File: rtl/wdt_mode_timer.sv
module wdt_mode_timer #(
    parameter int CNT_W    = 15,
    parameter int PRE_DIV  = 16,
    parameter int RST_HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_tick,
    input  logic ring_tick,
    input  logic src_sel,
    input  logic mode_sel,
    input  logic service_wr,
    input  logic hold,
    output logic irq_o,
    output logic rst_req_o
);
    import wdt_pkg::*;

    typedef struct packed {
        logic irq;
    } top_state_t;

    top_state_t cur_q, nxt_d;

    logic tick_src;
    logic tick_eff;
    logic step;
    logic underflow;
    logic fire_rst;

    always_comb begin
        tick_src = (wdt_src_e'(src_sel) == SRC_RING) ? ring_tick : cpu_tick;
        tick_eff = tick_src & ~hold;
    end

    wdt_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (service_wr),
        .tick  (tick_eff),
        .step  (step)
    );

    wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload    (service_wr),
        .step      (step),
        .underflow (underflow)
    );

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.irq = underflow && (wdt_act_e'(mode_sel) == ACT_IRQ);
        fire_rst  = underflow && (wdt_act_e'(mode_sel) == ACT_RESET);
    end

    wdt_reset_stretch #(.HOLD(RST_HOLD)) u_rst (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire_rst),
        .active (rst_req_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign irq_o = cur_q.irq;

endmodule

// File: rtl/wdt_mode_timer_chk.sv
module wdt_mode_timer_chk #(
    parameter int RST_HOLD = 16
) (
    input logic clk,
    input logic rst_n,
    input logic cpu_tick,
    input logic ring_tick,
    input logic src_sel,
    input logic mode_sel,
    input logic service_wr,
    input logic hold,
    input logic irq_o,
    input logic rst_req_o
);
    int run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_len <= 0;
        else if (rst_req_o) run_len <= run_len + 1;
        else                run_len <= 0;
    end

    // R2: a service write never coincides with an underflow
    a_r2_service_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        service_wr |=> (!irq_o && !$rose(rst_req_o)));

    // R5: the interrupt request lasts a single cycle
    a_r5_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R5, R9: an interrupt only follows an edge that sampled interrupt mode
    a_r9_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !$past(mode_sel));

    // R6, R9: a reset request only starts after an edge that sampled reset mode
    a_r6_rst_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> $past(mode_sel));

    // R6: the reset request stays high for exactly RST_HOLD cycles
    a_r6_rst_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req_o) |-> (run_len == RST_HOLD));

    // R8: no underflow comes from an edge that saw hold high
    a_r8_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!irq_o && !$rose(rst_req_o)));

endmodule

bind wdt_mode_timer wdt_mode_timer_chk #(.RST_HOLD(RST_HOLD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_tick   (cpu_tick),
    .ring_tick  (ring_tick),
    .src_sel    (src_sel),
    .mode_sel   (mode_sel),
    .service_wr (service_wr),
    .hold       (hold),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o)
);

// File: tb/wdt_mode_timer_tb.sv
module wdt_mode_timer_tb;
    localparam int CNT_W    = 4;
    localparam int PRE_DIV  = 4;
    localparam int RST_HOLD = 5;
    localparam int NTICK    = (1 << CNT_W) * PRE_DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_tick = 1'b0, ring_tick = 1'b0;
    logic src_sel = 1'b0, mode_sel = 1'b0, service_wr = 1'b0, hold = 1'b0;
    logic irq_o, rst_req_o;

    int n_checks = 0;
    int n_fail = 0;
    logic s_irq, s_rst;

    always #5 clk = ~clk;

    wdt_mode_timer #(.CNT_W(CNT_W), .PRE_DIV(PRE_DIV), .RST_HOLD(RST_HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .ring_tick(ring_tick),
        .src_sel(src_sel), .mode_sel(mode_sel), .service_wr(service_wr),
        .hold(hold), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // one tick on the chosen strobe; outputs sampled at the next falling edge
    task automatic tick_one(input bit ring, input bit with_service);
        @(negedge clk);
        cpu_tick   = !ring;
        ring_tick  = ring;
        service_wr = with_service;
        @(negedge clk);
        cpu_tick   = 1'b0;
        ring_tick  = 1'b0;
        service_wr = 1'b0;
        s_irq = irq_o;
        s_rst = rst_req_o;
    endtask

    task automatic service();
        @(negedge clk);
        service_wr = 1'b1;
        @(negedge clk);
        service_wr = 1'b0;
    endtask

    // ticks until the first event; returns its tick index or -1
    task automatic run_to_event(input bit ring, input int limit,
                                output int idx, output bit got_irq, output bit got_rst);
        idx = -1; got_irq = 0; got_rst = 0;
        for (int i = 1; i <= limit; i++) begin
            tick_one(ring, 1'b0);
            if (s_irq || s_rst) begin
                idx = i; got_irq = s_irq; got_rst = s_rst;
                break;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int idx;
        bit gi, gr;
        int width;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(irq_o == 1'b0, "R1 irq after reset", int'(irq_o), 0);
        check(rst_req_o == 1'b0, "R1 rst_req after reset", int'(rst_req_o), 0);

        // R1, R3, R5: first timeout counted from the reset state
        run_to_event(1'b0, 3 * NTICK, idx, gi, gr);
        check(idx == NTICK, "R3 first underflow tick", idx, NTICK);
        check(gi && !gr, "R5 irq action", int'(gi), 1);
        @(negedge clk);
        check(irq_o == 1'b0, "R5 irq single cycle", int'(irq_o), 0);

        // R7: automatic reload
        run_to_event(1'b0, 3 * NTICK, idx, gi, gr);
        check(idx == NTICK, "R7 reload period", idx, NTICK);

        // R2: service after every partial count restarts the full timeout
        for (int k = 1; k < NTICK; k++) begin
            service();
            for (int j = 0; j < k; j++) tick_one(1'b0, 1'b0);
            service();
            run_to_event(1'b0, 3 * NTICK, idx, gi, gr);
            check(idx == NTICK, "R2 service restart", idx, NTICK);
        end

        // R2: a tick coinciding with the service write is discarded
        service();
        for (int j = 0; j < PRE_DIV + 1; j++) tick_one(1'b0, 1'b0);
        tick_one(1'b0, 1'b1);
        run_to_event(1'b0, 3 * NTICK, idx, gi, gr);
        check(idx == NTICK, "R2 tick with service ignored", idx, NTICK);

        // R4: unselected strobe has no effect, selected one counts
        src_sel = 1'b1;
        service();
        run_to_event(1'b0, 2 * NTICK, idx, gi, gr);
        check(idx == -1, "R4 cpu strobe ignored on ring source", idx, -1);
        run_to_event(1'b1, 3 * NTICK, idx, gi, gr);
        check(idx == NTICK, "R4 ring source period", idx, NTICK);
        src_sel = 1'b0;
        service();
        run_to_event(1'b1, 2 * NTICK, idx, gi, gr);
        check(idx == -1, "R4 ring strobe ignored on cpu source", idx, -1);
        service();

        // R8: ticks under hold are frozen out
        @(negedge clk);
        hold = 1'b1;
        run_to_event(1'b0, 2 * NTICK, idx, gi, gr);
        check(idx == -1, "R8 no event while held", idx, -1);
        @(negedge clk);
        hold = 1'b0;
        run_to_event(1'b0, 3 * NTICK, idx, gi, gr);
        check(idx == NTICK, "R8 count resumes unchanged", idx, NTICK);

        // R6: reset action and its length
        mode_sel = 1'b1;
        service();
        run_to_event(1'b0, 3 * NTICK, idx, gi, gr);
        check(idx == NTICK, "R6 reset mode period", idx, NTICK);
        check(gr && !gi, "R6 reset request without irq", int'(gi), 0);
        width = 1;
        while (1) begin
            @(negedge clk);
            if (!rst_req_o || width > 4 * RST_HOLD) break;
            width++;
        end
        check(width == RST_HOLD, "R6 reset request width", width, RST_HOLD);

        // R9: action taken from mode at the underflow edge
        service();
        for (int j = 0; j < NTICK - 1; j++) tick_one(1'b0, 1'b0);
        check(!s_rst && !s_irq, "R9 no early event", int'(s_rst), 0);
        @(negedge clk);
        mode_sel = 1'b0;
        tick_one(1'b0, 1'b0);
        check(s_irq && !s_rst, "R9 late switch to irq", int'(s_irq), 1);
        for (int j = 0; j < NTICK - 1; j++) tick_one(1'b0, 1'b0);
        @(negedge clk);
        mode_sel = 1'b1;
        tick_one(1'b0, 1'b0);
        check(s_rst && !s_irq, "R9 late switch to reset", int'(s_rst), 1);

        repeat (RST_HOLD + 2) @(negedge clk);
        summary();
        $finish;
    end

endmodule